// File: doc/BRIEF.md
# 32-bit Integer ALU with Shifts

This block is the combinational arithmetic and logic unit of a 32-bit integer datapath. It takes two operands and a 4-bit operation code and produces one 32-bit result in the same cycle. The result is not registered, so the surrounding pipeline stage captures it.

The supported operations are add, subtract, bitwise AND, OR and XOR, and three shifts: left logical, right logical and right arithmetic. The two right shifts are separate operations. The arithmetic right shift keeps the sign, so a negative odd value rounds toward negative infinity. The caller picks the second operand (a register value or a sign-extended immediate) before it reaches the block. There are no flags, traps, multiply or divide.

Top module: `int_alu32`

## Requirements
- R1: With op code 0 the result is the sum of the two operands modulo 2^32, and the carry out of bit 31 is dropped.
- R2: With op code 1 the result is the first operand minus the second, modulo 2^32.
- R3: Op codes 2, 3 and 4 give the bitwise AND, OR and XOR of the operands across all 32 bits.
- R4: Op code 5 shifts the first operand left and fills the vacated low bits with zeros. Bits moved past bit 31 are lost. For example, 0x00000002 shifted by 2 gives 0x00000008.
- R5: Op code 6 shifts the first operand right and fills the vacated high bits with zeros.
- R6: Op code 7 shifts the first operand right and copies its bit 31 into every vacated high bit. For example, 0xFFFFFFE7 shifted by 4 gives 0xFFFFFFFE.
- R7: Every shift takes its amount from bits 4:0 of the second operand. Bits 31:5 of the second operand do not change a shift result.
- R8: Op codes 8 through 15 give a result of zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 4 | Operation code |
| opnd_a | input | 32 | First operand; also the value that is shifted |
| opnd_b | input | 32 | Second operand; bits 4:0 are the shift amount |
| result | output | 32 | Result of the selected operation |

## Verification
The built-in checks assume that the inputs are stable, two-state values whenever they are evaluated. Each check states an algebraic relation of the selected operation, for example that the sum minus the second operand gives back the first operand. The bench changes the inputs only at the rising clock edge and compares the output at the falling edge, so every compare sees settled values. The stimulus covers all sixteen op codes. It includes sign-boundary and all-ones operands, shift amounts 0 and 31, and second operands whose upper bits are set, and it adds random operands.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_AND = 4'd2,
        OP_OR  = 4'd3,
        OP_XOR = 4'd4,
        OP_SLL = 4'd5,
        OP_SRL = 4'd6,
        OP_SRA = 4'd7
    } alu_op_e;

    typedef enum logic [1:0] {
        BW_AND = 2'd0,
        BW_OR  = 2'd1,
        BW_XOR = 2'd2
    } bw_sel_e;

    typedef enum logic [1:0] {
        RES_ZERO  = 2'd0,
        RES_ARITH = 2'd1,
        RES_BW    = 2'd2,
        RES_SHIFT = 2'd3
    } res_src_e;

    // Control word decoded from the operation code.
    typedef struct packed {
        res_src_e src;
        logic     negate_b;
        bw_sel_e  bw;
        logic     shl;
        logic     sign_fill;
    } alu_ctl_t;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int XLEN = 32
) (
    input  logic            negate_b,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] sum
);
    logic [XLEN-1:0] b_eff_d;
    logic [XLEN:0]   wide_d;

    always_comb begin
        b_eff_d = negate_b ? ~b : b;
        wide_d  = {1'b0, a} + {1'b0, b_eff_d} + {{XLEN{1'b0}}, negate_b};
        sum     = wide_d[XLEN-1:0];
    end

    always_comb begin
        if (!negate_b) begin
            a_r1_add_inverse: assert (sum - b == a)
                else $error("R1 sum does not invert");
        end else begin
            a_r2_sub_inverse: assert (sum + b == a)
                else $error("R2 difference does not invert");
        end
    end
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise #(
    parameter int XLEN = 32
) (
    input  alu_pkg::bw_sel_e sel,
    input  logic [XLEN-1:0]  a,
    input  logic [XLEN-1:0]  b,
    output logic [XLEN-1:0]  y
);
    import alu_pkg::*;

    always_comb begin
        unique case (sel)
            BW_AND:  y = a & b;
            BW_OR:   y = a | b;
            BW_XOR:  y = a ^ b;
            default: y = '0;
        endcase
    end

    always_comb begin
        if (sel == BW_AND) begin
            a_r3_and_subset: assert (((y & ~a) | (y & ~b)) == '0)
                else $error("R3 AND sets a bit absent from an operand");
        end
        if (sel == BW_OR) begin
            a_r3_or_cover: assert (((a | b) & ~y) == '0 && (y & ~(a | b)) == '0)
                else $error("R3 OR mismatch");
        end
        if (sel == BW_XOR) begin
            a_r3_xor_inverse: assert ((y ^ b) == a)
                else $error("R3 XOR does not invert");
        end
    end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
    parameter int XLEN = 32,
    localparam int SHW = $clog2(XLEN)
) (
    input  logic            shl,
    input  logic            sign_fill,
    input  logic [XLEN-1:0] a,
    input  logic [SHW-1:0]  amt,
    output logic [XLEN-1:0] y
);
    // A left shift reuses the right-shift stages on bit-reversed data.
    logic [XLEN-1:0] rev_in;
    logic [XLEN-1:0] rev_out;
    logic [XLEN-1:0] stage [SHW+1];
    logic            fill_d;

    assign fill_d = sign_fill & ~shl & a[XLEN-1];

    for (genvar i = 0; i < XLEN; i++) begin : g_rev
        assign rev_in[i]  = a[XLEN-1-i];
        assign rev_out[i] = stage[SHW][XLEN-1-i];
    end

    assign stage[0] = shl ? rev_in : a;

    for (genvar k = 0; k < SHW; k++) begin : g_stage
        localparam int STEP = 1 << k;
        assign stage[k+1] = amt[k] ? {{STEP{fill_d}}, stage[k][XLEN-1:STEP]}
                                   : stage[k];
    end

    assign y = shl ? rev_out : stage[SHW];

    always_comb begin
        if (shl) begin
            a_r4_low_zero: assert ((y & ((XLEN'(1) << amt) - XLEN'(1))) == '0)
                else $error("R4 vacated low bits not zero");
        end else if (!sign_fill && amt != '0) begin
            a_r5_high_zero: assert (y[XLEN-1] == 1'b0)
                else $error("R5 vacated high bit not zero");
        end else if (sign_fill) begin
            a_r6_sign_kept: assert (y[XLEN-1] == a[XLEN-1])
                else $error("R6 sign bit not kept");
        end
    end
endmodule

// File: rtl/int_alu32.sv
module int_alu32 #(
    parameter int XLEN = 32,
    localparam int SHW = $clog2(XLEN)
) (
    input  logic [3:0]      op_sel,
    input  logic [XLEN-1:0] opnd_a,
    input  logic [XLEN-1:0] opnd_b,
    output logic [XLEN-1:0] result
);
    import alu_pkg::*;

    alu_ctl_t        ctl_d;
    logic [XLEN-1:0] arith_d;
    logic [XLEN-1:0] bw_d;
    logic [XLEN-1:0] shift_d;

    always_comb begin
        ctl_d = '{src: RES_ZERO, negate_b: 1'b0, bw: BW_AND, shl: 1'b0, sign_fill: 1'b0};
        case (op_sel)
            OP_ADD: ctl_d.src = RES_ARITH;
            OP_SUB: begin ctl_d.src = RES_ARITH; ctl_d.negate_b = 1'b1; end
            OP_AND: begin ctl_d.src = RES_BW; ctl_d.bw = BW_AND; end
            OP_OR:  begin ctl_d.src = RES_BW; ctl_d.bw = BW_OR;  end
            OP_XOR: begin ctl_d.src = RES_BW; ctl_d.bw = BW_XOR; end
            OP_SLL: begin ctl_d.src = RES_SHIFT; ctl_d.shl = 1'b1; end
            OP_SRL: ctl_d.src = RES_SHIFT;
            OP_SRA: begin ctl_d.src = RES_SHIFT; ctl_d.sign_fill = 1'b1; end
            default: ctl_d.src = RES_ZERO;
        endcase
    end

    alu_addsub #(.XLEN(XLEN)) u_addsub (
        .negate_b (ctl_d.negate_b),
        .a        (opnd_a),
        .b        (opnd_b),
        .sum      (arith_d)
    );

    alu_bitwise #(.XLEN(XLEN)) u_bitwise (
        .sel (ctl_d.bw),
        .a   (opnd_a),
        .b   (opnd_b),
        .y   (bw_d)
    );

    alu_shifter #(.XLEN(XLEN)) u_shifter (
        .shl       (ctl_d.shl),
        .sign_fill (ctl_d.sign_fill),
        .a         (opnd_a),
        .amt       (opnd_b[SHW-1:0]),
        .y         (shift_d)
    );

    always_comb begin
        unique case (ctl_d.src)
            RES_ARITH: result = arith_d;
            RES_BW:    result = bw_d;
            RES_SHIFT: result = shift_d;
            default:   result = '0;
        endcase
    end

    always_comb begin
        if (op_sel[3]) begin
            a_r8_unused_zero: assert (result == '0)
                else $error("R8 unused code gave a nonzero result");
        end
        if (op_sel == 4'd5 && opnd_b[SHW-1:0] == '0) begin
            a_r7_zero_amount: assert (result == opnd_a)
                else $error("R7 zero shift amount changed the value");
        end
    end
endmodule

// File: tb/int_alu32_tb.sv
module int_alu32_tb;
    logic        clk = 1'b0;
    logic [3:0]  op_sel = '0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [31:0] result;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    int_alu32 u_dut (.op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result));

    function automatic logic [31:0] model(input logic [3:0] op, input logic [31:0] a,
                                          input logic [31:0] b);
        int unsigned n = b % 32;
        case (op)
            4'd0: return a + b;
            4'd1: return a - b;
            4'd2: return a & b;
            4'd3: return a | b;
            4'd4: return a ^ b;
            4'd5: return a << n;
            4'd6: return a >> n;
            4'd7: return $unsigned($signed(a) >>> n);
            default: return 32'd0;
        endcase
    endfunction

    function automatic string tag(input logic [3:0] op, input logic [31:0] b);
        if (op >= 4'd5 && op <= 4'd7 && b[31:5] != '0) return "R7";
        case (op)
            4'd0: return "R1";
            4'd1: return "R2";
            4'd2, 4'd3, 4'd4: return "R3";
            4'd5: return "R4";
            4'd6: return "R5";
            4'd7: return "R6";
            default: return "R8";
        endcase
    endfunction

    task automatic apply(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
        logic [31:0] exp;
        @(posedge clk);
        op_sel = op; opnd_a = a; opnd_b = b;
        exp = model(op, a, b);
        @(negedge clk);
        checks++;
        if (result !== exp) begin
            errors++;
            $display("FAIL %s op=%0d a=%h b=%h actual=%h expected=%h",
                     tag(op, b), op, a, b, result, exp);
        end
    endtask

    task automatic fixed(input string t, input logic [3:0] op, input logic [31:0] a,
                         input logic [31:0] b, input logic [31:0] exp);
        @(posedge clk);
        op_sel = op; opnd_a = a; opnd_b = b;
        @(negedge clk);
        checks++;
        if (result !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", t, result, exp);
        end
    endtask

    initial begin
        logic [31:0] edges [8] = '{32'h0, 32'h1, 32'h7FFF_FFFF, 32'h8000_0000,
                                   32'hFFFF_FFFF, 32'hFFFF_FFE7, 32'h0000_001F, 32'hA5A5_5A5A};
        // reset state: all-zero inputs give zero
        fixed("R1", 4'd0, 32'h0, 32'h0, 32'h0);
        fixed("R1", 4'd0, 32'hFFFF_FFFF, 32'h1, 32'h0);
        fixed("R2", 4'd1, 32'h0, 32'h1, 32'hFFFF_FFFF);
        fixed("R3", 4'd4, 32'hF0F0_F0F0, 32'hFFFF_0000, 32'h0F0F_F0F0);
        fixed("R4", 4'd5, 32'h2, 32'h2, 32'h8);
        fixed("R4", 4'd5, 32'hC000_0001, 32'h1F, 32'h8000_0000);
        fixed("R5", 4'd6, 32'h8000_0000, 32'h1F, 32'h1);
        fixed("R6", 4'd7, 32'hFFFF_FFE7, 32'h4, 32'hFFFF_FFFE);
        fixed("R6", 4'd7, 32'h8000_0000, 32'h1F, 32'hFFFF_FFFF);
        fixed("R7", 4'd6, 32'hF000_0000, 32'hFFFF_FFE4, 32'h0F00_0000);
        fixed("R7", 4'd5, 32'h1, 32'h0000_0020, 32'h1);
        fixed("R8", 4'd8, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0);
        for (int op = 0; op < 16; op++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    apply(4'(op), edges[i], edges[j]);
        for (int n = 0; n < 3000; n++)
            apply(4'($urandom_range(0, 15)), $urandom, $urandom);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule